// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block holds a small set of recent page mappings so that the address path can turn a virtual address into a physical one without walking the page table. Every entry has a virtual page number tag, a physical frame number and six state bits. Any mapping can sit in any entry. A lookup compares the page-number part of the incoming address with every entry at once. One cycle later the block reports a hit, a protection fault or a miss. On a hit it returns the physical address, which is the stored frame number placed above the unchanged page offset.

When a miss occurs, the walker loads the mapping through the fill port. If a free entry exists, the fill places the mapping there. If the table is full, the fill evicts the entry under a round-robin pointer. If the page is already resident, the fill rewrites that entry in place. A flush input empties the whole table in a single cycle. The entry count is a parameter and may be at most 64.

Top module: `tlb_fa`

## Requirements
- R1: After reset, no entry is valid, and `lkp_vld_o`, `lkp_hit_o` and `lkp_fault_o` are low while `lkp_pa_o` and `lkp_flags_o` are zero. A lookup issued at that point reports a miss.
- R2: A request sampled at a clock edge presents its result after that edge, with `lkp_vld_o` high for exactly one cycle. On cycles with no request, `lkp_vld_o` is low and the hit, fault, address and flag outputs keep their last values.
- R3: On a miss (no valid entry whose tag equals address bits [VA_W-1:OFF_W]), the block reports `lkp_hit_o`=0, `lkp_fault_o`=0, `lkp_pa_o`=0 and `lkp_flags_o`=0.
- R4: On a permitted hit, `lkp_pa_o` is {frame, offset}, where the offset is address bits [OFF_W-1:0]. `lkp_flags_o` returns the stored flags, encoded as bit0 read, bit1 write, bit2 execute, bit3 cacheable, bit4 referenced and bit5 modified.
- R5: The access mask `lkp_acc_i` uses bit0 for read, bit1 for write and bit2 for execute. If a matching entry lacks any requested right in flag bits [2:0], the result is `lkp_fault_o`=1, `lkp_hit_o`=0 and `lkp_pa_o`=0, and `lkp_flags_o` carries the stored flags.
- R6: A fill of a page that is not resident goes to the lowest-numbered free entry. While any entry is free, no resident mapping is evicted.
- R7: A fill of a page that is already resident rewrites that entry in place. It evicts nothing and leaves the replacement pointer where it was.
- R8: A fill into a full table evicts the entry under the round-robin pointer. The pointer starts at entry 0 after reset, advances by one on each eviction and wraps after the last entry.
- R9: `flush_i` invalidates every entry in one cycle. A fill in the same cycle is discarded.
- R10: A lookup in the same cycle as a fill sees the table as it was before the fill. A request in the next cycle sees the new mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| lkp_req_i | input | 1 | Lookup request |
| lkp_va_i | input | VA_W | Virtual address to translate |
| lkp_acc_i | input | 3 | Rights needed: bit0 read, bit1 write, bit2 execute |
| fill_i | input | 1 | Install a mapping |
| fill_vpn_i | input | VPN_W | Virtual page number to install |
| fill_pfn_i | input | PFN_W | Frame number to install |
| fill_flags_i | input | 6 | State bits to install |
| lkp_vld_o | output | 1 | Result valid, one cycle after a request |
| lkp_hit_o | output | 1 | Permitted hit |
| lkp_fault_o | output | 1 | Matching entry lacks a requested right |
| lkp_pa_o | output | PFN_W+OFF_W | Physical address, zero unless hit |
| lkp_flags_o | output | 6 | Stored state bits of the matching entry, zero on miss |

## Verification
The lookup path is exercised in three ways: with resident pages, with a non-resident page, and with access masks that the stored flags deny. This separates a hit from a miss and a hit from a protection fault, and the offsets at both ends of the page range show that the offset passes through unchanged. Fill sequences give three further cases: rewriting a resident page, filling into free entries, and filling into a full table. Each ends with lookups of the mappings that should have survived and of those that should have been evicted. This separates in-place update, lowest-free placement and the order of the round-robin victims. Flush alone, flush together with a fill, and a lookup in the same cycle as a fill cover invalidation priority and which table state a lookup sees.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int FLAG_W = 6;
  localparam int ACC_W  = 3;

  function automatic logic perm_ok(input logic [ACC_W-1:0] need, input logic [FLAG_W-1:0] flg);
    return (need & ~flg[ACC_W-1:0]) == '0;
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N_ENTRIES = 16,
  parameter int VPN_W     = 20
) (
  input  logic [VPN_W-1:0]     vpn_i,
  input  logic                 valid_i [N_ENTRIES],
  input  logic [VPN_W-1:0]     tag_i   [N_ENTRIES],
  output logic [N_ENTRIES-1:0] match_o
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == vpn_i);
  end
endmodule

// File: rtl/tlb_rdmux.sv
module tlb_rdmux #(
  parameter int N_ENTRIES = 16,
  parameter int W         = 20
) (
  input  logic [N_ENTRIES-1:0] sel_i,
  input  logic [W-1:0]         data_i [N_ENTRIES],
  output logic [W-1:0]         data_o
);
  // sel_i is one-hot or zero, so an AND-OR tree suffices
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      data_o = data_o | (data_i[i] & {W{sel_i[i]}});
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fill_i,
  input  logic                 flush_i,
  input  logic [N_ENTRIES-1:0] valid_i,
  input  logic [N_ENTRIES-1:0] dup_i,
  output logic [N_ENTRIES-1:0] wr_en_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;
  logic             evict;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (!valid_i[i] && !free_found) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign evict = fill_i && !flush_i && !(|dup_i) && !free_found;

  always_comb begin
    wr_en_o = '0;
    if (fill_i && !flush_i) begin
      if (|dup_i)          wr_en_o = dup_i;
      else if (free_found) wr_en_o[free_idx] = 1'b1;
      else                 wr_en_o[ptr_q] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (evict) begin
      if (ptr_q == IDX_W'(N_ENTRIES - 1)) ptr_q <= '0;
      else                                ptr_q <= ptr_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int VPN_W     = 20,
  parameter int PFN_W     = 20,
  parameter int OFF_W     = 12,
  localparam int VA_W     = VPN_W + OFF_W,
  localparam int PA_W     = PFN_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              lkp_req_i,
  input  logic [VA_W-1:0]   lkp_va_i,
  input  logic [ACC_W-1:0]  lkp_acc_i,
  input  logic              fill_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [FLAG_W-1:0] fill_flags_i,
  output logic              lkp_vld_o,
  output logic              lkp_hit_o,
  output logic              lkp_fault_o,
  output logic [PA_W-1:0]   lkp_pa_o,
  output logic [FLAG_W-1:0] lkp_flags_o
);
  logic                 valid_q [N_ENTRIES];
  logic [VPN_W-1:0]     tag_q   [N_ENTRIES];
  logic [PFN_W-1:0]     pfn_q   [N_ENTRIES];
  logic [FLAG_W-1:0]    flg_q   [N_ENTRIES];
  logic [N_ENTRIES-1:0] valid_vec;
  logic [N_ENTRIES-1:0] wr_en;
  logic [N_ENTRIES-1:0] lkp_match;
  logic [N_ENTRIES-1:0] fill_match;

  logic [VPN_W-1:0]  lkp_vpn;
  logic [OFF_W-1:0]  lkp_off;
  logic [PFN_W-1:0]  sel_pfn;
  logic [FLAG_W-1:0] sel_flg;
  logic              any_hit;
  logic              allowed;

  assign lkp_vpn = lkp_va_i[VA_W-1:OFF_W];
  assign lkp_off = lkp_va_i[OFF_W-1:0];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    assign valid_vec[g] = valid_q[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        pfn_q[g]   <= '0;
        flg_q[g]   <= '0;
      end else if (flush_i) begin
        valid_q[g] <= 1'b0;
      end else if (wr_en[g]) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= fill_vpn_i;
        pfn_q[g]   <= fill_pfn_i;
        flg_q[g]   <= fill_flags_i;
      end
    end
  end

  tlb_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W)) u_lkp_match (
    .vpn_i  (lkp_vpn),
    .valid_i(valid_q),
    .tag_i  (tag_q),
    .match_o(lkp_match)
  );

  // fill-side compare keeps tags unique
  tlb_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W)) u_fill_match (
    .vpn_i  (fill_vpn_i),
    .valid_i(valid_q),
    .tag_i  (tag_q),
    .match_o(fill_match)
  );

  tlb_victim #(.N_ENTRIES(N_ENTRIES)) u_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fill_i (fill_i),
    .flush_i(flush_i),
    .valid_i(valid_vec),
    .dup_i  (fill_match),
    .wr_en_o(wr_en)
  );

  tlb_rdmux #(.N_ENTRIES(N_ENTRIES), .W(PFN_W)) u_pfn_mux (
    .sel_i (lkp_match),
    .data_i(pfn_q),
    .data_o(sel_pfn)
  );

  tlb_rdmux #(.N_ENTRIES(N_ENTRIES), .W(FLAG_W)) u_flg_mux (
    .sel_i (lkp_match),
    .data_i(flg_q),
    .data_o(sel_flg)
  );

  assign any_hit = |lkp_match;
  assign allowed = perm_ok(lkp_acc_i, sel_flg);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lkp_vld_o   <= 1'b0;
      lkp_hit_o   <= 1'b0;
      lkp_fault_o <= 1'b0;
      lkp_pa_o    <= '0;
      lkp_flags_o <= '0;
    end else begin
      lkp_vld_o <= lkp_req_i;
      if (lkp_req_i) begin
        lkp_hit_o   <= any_hit && allowed;
        lkp_fault_o <= any_hit && !allowed;
        lkp_pa_o    <= (any_hit && allowed) ? {sel_pfn, lkp_off} : '0;
        lkp_flags_o <= any_hit ? sel_flg : '0;
      end
    end
  end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int N_ENTRIES = 16,
  parameter int PA_W      = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 flush_i,
  input logic                 lkp_req_i,
  input logic                 lkp_vld_o,
  input logic                 lkp_hit_o,
  input logic                 lkp_fault_o,
  input logic [PA_W-1:0]      lkp_pa_o,
  input logic [N_ENTRIES-1:0] valid_vec,
  input logic [N_ENTRIES-1:0] wr_en,
  input logic [N_ENTRIES-1:0] lkp_match
);
  assert_vld_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_req_i |=> lkp_vld_o);

  assert_vld_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_req_i |=> !lkp_vld_o);

  assert_miss_pa_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_vld_o && !lkp_hit_o) |-> (lkp_pa_o == '0));

  assert_hit_fault_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lkp_hit_o && lkp_fault_o));

  assert_one_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en));

  assert_unique_tag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lkp_match) <= 1);

  assert_full_stays_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_vec && !flush_i) |=> &valid_vec);

  assert_flush_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_vec == '0));
endmodule

bind tlb_fa tlb_fa_chk #(.N_ENTRIES(N_ENTRIES), .PA_W(PA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .flush_i    (flush_i),
  .lkp_req_i  (lkp_req_i),
  .lkp_vld_o  (lkp_vld_o),
  .lkp_hit_o  (lkp_hit_o),
  .lkp_fault_o(lkp_fault_o),
  .lkp_pa_o   (lkp_pa_o),
  .valid_vec  (valid_vec),
  .wr_en      (wr_en),
  .lkp_match  (lkp_match)
);

// File: tb/tlb_fa_bench.sv
`timescale 1ns/1ps
module tlb_fa_bench;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req = 1'b0;
  logic [31:0] va = '0;
  logic [2:0]  acc = '0;
  logic        fill = 1'b0;
  logic [19:0] fvpn = '0;
  logic [19:0] fpfn = '0;
  logic [5:0]  fflg = '0;
  logic        vld, hit, fault;
  logic [31:0] pa;
  logic [5:0]  flg;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  tlb_fa #(.N_ENTRIES(N)) u_tlb_fa (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .lkp_req_i(req), .lkp_va_i(va), .lkp_acc_i(acc),
    .fill_i(fill), .fill_vpn_i(fvpn), .fill_pfn_i(fpfn), .fill_flags_i(fflg),
    .lkp_vld_o(vld), .lkp_hit_o(hit), .lkp_fault_o(fault),
    .lkp_pa_o(pa), .lkp_flags_o(flg)
  );

  typedef struct packed {
    logic        is_fill;
    logic [7:0]  rq;
    logic [19:0] vpn;
    logic [11:0] off;
    logic [19:0] pfn;
    logic [5:0]  flags;
    logic [2:0]  acc;
    logic        e_hit;
    logic        e_fault;
    logic [31:0] e_pa;
    logic [5:0]  e_flg;
  } vec_t;

  localparam int NV = 18;
  // flags: b0 rd b1 wr b2 ex b3 cache b4 ref b5 mod; acc: b0 rd b1 wr b2 ex
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd6,  20'h00010, 12'h000, 20'h00A10, 6'h0B, 3'b000, 1'b0, 1'b0, 32'h0,         6'h00}, // R6 -> entry 0
    '{1'b1, 8'd6,  20'h00020, 12'h000, 20'h00A20, 6'h05, 3'b000, 1'b0, 1'b0, 32'h0,         6'h00}, // R6 -> entry 1
    '{1'b0, 8'd4,  20'h00010, 12'h123, 20'h0,     6'h00, 3'b001, 1'b1, 1'b0, 32'h00A10123,  6'h0B}, // R4
    '{1'b0, 8'd4,  20'h00020, 12'hFFF, 20'h0,     6'h00, 3'b100, 1'b1, 1'b0, 32'h00A20FFF,  6'h05}, // R4
    '{1'b0, 8'd5,  20'h00020, 12'h000, 20'h0,     6'h00, 3'b010, 1'b0, 1'b1, 32'h0,         6'h05}, // R5
    '{1'b0, 8'd3,  20'h00030, 12'h000, 20'h0,     6'h00, 3'b001, 1'b0, 1'b0, 32'h0,         6'h00}, // R3
    '{1'b1, 8'd7,  20'h00010, 12'h000, 20'h00B10, 6'h3F, 3'b000, 1'b0, 1'b0, 32'h0,         6'h00}, // R7 rewrite
    '{1'b0, 8'd7,  20'h00010, 12'h004, 20'h0,     6'h00, 3'b111, 1'b1, 1'b0, 32'h00B10004,  6'h3F}, // R7
    '{1'b0, 8'd7,  20'h00020, 12'h008, 20'h0,     6'h00, 3'b001, 1'b1, 1'b0, 32'h00A20008,  6'h05}, // R7
    '{1'b1, 8'd6,  20'h00030, 12'h000, 20'h00A30, 6'h07, 3'b000, 1'b0, 1'b0, 32'h0,         6'h00}, // R6
    '{1'b1, 8'd6,  20'h00040, 12'h000, 20'h00A40, 6'h07, 3'b000, 1'b0, 1'b0, 32'h0,         6'h00}, // R6 full
    '{1'b1, 8'd8,  20'h00050, 12'h000, 20'h00A50, 6'h07, 3'b000, 1'b0, 1'b0, 32'h0,         6'h00}, // R8 evict 0
    '{1'b0, 8'd8,  20'h00010, 12'h000, 20'h0,     6'h00, 3'b001, 1'b0, 1'b0, 32'h0,         6'h00}, // R8
    '{1'b0, 8'd8,  20'h00050, 12'h000, 20'h0,     6'h00, 3'b001, 1'b1, 1'b0, 32'h00A50000,  6'h07}, // R8
    '{1'b1, 8'd8,  20'h00060, 12'h000, 20'h00A60, 6'h07, 3'b000, 1'b0, 1'b0, 32'h0,         6'h00}, // R8 evict 1
    '{1'b0, 8'd8,  20'h00020, 12'h000, 20'h0,     6'h00, 3'b001, 1'b0, 1'b0, 32'h0,         6'h00}, // R8
    '{1'b0, 8'd8,  20'h00030, 12'h000, 20'h0,     6'h00, 3'b001, 1'b1, 1'b0, 32'h00A30000,  6'h07}, // R8
    '{1'b0, 8'd8,  20'h00060, 12'h010, 20'h0,     6'h00, 3'b001, 1'b1, 1'b0, 32'h00A60010,  6'h07}  // R8
  };

  task automatic chk(input string what, input int r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d %s got=%h exp=%h", r, what, got, exp);
    end
  endtask

  task automatic do_fill(input logic [19:0] v, input logic [19:0] p, input logic [5:0] f);
    fill = 1'b1; fvpn = v; fpfn = p; fflg = f;
    @(negedge clk);
    fill = 1'b0;
  endtask

  task automatic do_lookup(input logic [19:0] v, input logic [11:0] o, input logic [2:0] a);
    req = 1'b1; va = {v, o}; acc = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic expect_res(input int r, input logic h, input logic f, input logic [31:0] p, input logic [5:0] fl);
    chk("vld", 2, {31'b0, vld}, 32'd1);
    chk("hit", r, {31'b0, hit}, {31'b0, h});
    chk("fault", r, {31'b0, fault}, {31'b0, f});
    chk("pa", r, pa, p);
    chk("flags", r, {26'b0, flg}, {26'b0, fl});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("reset vld", 1, {31'b0, vld}, 32'd0);
    chk("reset hit", 1, {31'b0, hit}, 32'd0);
    chk("reset fault", 1, {31'b0, fault}, 32'd0);
    chk("reset pa", 1, pa, 32'd0);
    do_lookup(20'h00000, 12'h000, 3'b001);
    expect_res(1, 1'b0, 1'b0, 32'h0, 6'h00);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_fill) begin
        do_fill(VECS[i].vpn, VECS[i].pfn, VECS[i].flags);
      end else begin
        do_lookup(VECS[i].vpn, VECS[i].off, VECS[i].acc);
        expect_res(int'(VECS[i].rq), VECS[i].e_hit, VECS[i].e_fault, VECS[i].e_pa, VECS[i].e_flg);
      end
    end

    // R2 idle cycle: vld drops, results hold
    @(negedge clk);
    chk("idle vld", 2, {31'b0, vld}, 32'd0);
    chk("hold hit", 2, {31'b0, hit}, 32'd1);
    chk("hold pa", 2, pa, 32'h00A60010);

    // R9 flush
    do_flush();
    do_lookup(20'h00030, 12'h000, 3'b001);
    expect_res(9, 1'b0, 1'b0, 32'h0, 6'h00);
    do_lookup(20'h00050, 12'h000, 3'b001);
    expect_res(9, 1'b0, 1'b0, 32'h0, 6'h00);

    // R9 flush beats fill
    flush = 1'b1; fill = 1'b1; fvpn = 20'h00070; fpfn = 20'h00A70; fflg = 6'h07;
    @(negedge clk);
    flush = 1'b0; fill = 1'b0;
    do_lookup(20'h00070, 12'h000, 3'b001);
    expect_res(9, 1'b0, 1'b0, 32'h0, 6'h00);

    // R6 fills into free entries keep all mappings
    for (int k = 0; k < N; k++) do_fill(20'h00100 + 20'(k), 20'h00C00 + 20'(k), 6'h01);
    for (int k = 0; k < N; k++) begin
      do_lookup(20'h00100 + 20'(k), 12'h055, 3'b001);
      expect_res(6, 1'b1, 1'b0, {20'h00C00 + 20'(k), 12'h055}, 6'h01);
    end

    // R10 lookup concurrent with fill sees old contents
    do_flush();
    fill = 1'b1; fvpn = 20'h00080; fpfn = 20'h00A80; fflg = 6'h01;
    req = 1'b1; va = {20'h00080, 12'h000}; acc = 3'b001;
    @(negedge clk);
    fill = 1'b0; req = 1'b0;
    expect_res(10, 1'b0, 1'b0, 32'h0, 6'h00);
    do_lookup(20'h00080, 12'h000, 3'b001);
    expect_res(10, 1'b1, 1'b0, 32'h00A80000, 6'h01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule